// File: doc/BRIEF.md
# Stream Fan-out Broadcaster

This stage takes items from one valid/ready input stream and offers a copy of each to N output streams. An item leaves the input only after every output has taken it. The stage is used when one producer must feed several consumers that each need every item, such as a result that goes both to a writer and to a checker.

A compile-time parameter picks one of two modes. In lockstep mode the outputs all accept an item in the same cycle, and the stage waits until every consumer is ready at once. In independent mode each consumer may take the item in its own cycle. One flag per output records which copies have already left. The input handshake completes in the cycle the last outstanding copy is taken. The payload width and the number of outputs are parameters.

Top module: `stream_fanout`

## Requirements
- R1: Every output data slice (output k occupies bits k*DATA_W upward) carries the same value as `in_data` in every cycle.
- R2: In lockstep mode `in_ready` is the AND of all `out_ready` bits, whatever the state of `in_valid`.
- R3: In lockstep mode `out_valid[k]` is high only when `in_valid` is high and every other output's ready is high, so that no output fires unless all of them fire.
- R4: In independent mode, once output k has fired for the current item, `out_valid[k]` stays low until the input item is accepted. The other outputs keep offering the item.
- R5: In independent mode `in_ready` is high exactly when each output is either ready now or has already taken the current item. This holds whatever the state of `in_valid`.
- R6: In independent mode, in the cycle after the input is accepted, all sent-flags are clear, and every output offers the next item while `in_valid` is high.
- R7: Reset (active-low `rst_n`) clears all sent-flags, so after reset every output offers the first item.
- R8: While `in_valid` is low, all `out_valid` bits are low and no sent-flag changes, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Input item consumed this cycle when high with in_valid |
| in_data | input | DATA_W | Input payload |
| out_valid | output | N_OUT | Per-output item present |
| out_ready | input | N_OUT | Per-output consumer ready |
| out_data | output | N_OUT*DATA_W | Payload copies, output k in slice k |

## Verification
Both modes are driven with the same walk of ready patterns. The patterns are all ready, no ready, a single ready that moves across the outputs over successive cycles, and a pair ready together, with the input held and with it idle. Readies that arrive one per cycle separate the modes: independent mode finishes the item after the last one, while lockstep mode never fires. A pattern with the same output ready twice shows that a copy is not offered again after it has left. A reset with one copy already sent shows that the flags are cleared, and an idle input with all outputs ready shows that nothing is sent and that no flag changes.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

    typedef enum logic {
        FORK_LOCKSTEP    = 1'b0,
        FORK_INDEPENDENT = 1'b1
    } fork_mode_e;

endpackage

// File: rtl/fanout_sent_flags.sv
module fanout_sent_flags #(
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fire,
    input  logic [N_OUT-1:0] out_fire,
    output logic [N_OUT-1:0] sent
);

    typedef struct packed {
        logic [N_OUT-1:0] sent;
    } flags_t;

    flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_fire) begin
            st_d.sent = '0;
        end else begin
            st_d.sent = st_q.sent | out_fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sent = st_q.sent;

endmodule

// File: rtl/fanout_offer.sv
module fanout_offer #(
    parameter int  N_OUT    = 3,
    parameter bit  LOCKSTEP = 1'b0
) (
    input  logic             in_valid,
    input  logic [N_OUT-1:0] sent,
    input  logic [N_OUT-1:0] out_ready,
    output logic [N_OUT-1:0] out_valid,
    output logic             in_ready
);

    localparam logic [N_OUT-1:0] ONE = N_OUT'(1);

    logic [N_OUT-1:0] others_ready;

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        assign others_ready[g] = &(out_ready | (ONE << g));
        if (LOCKSTEP) begin : g_lock
            assign out_valid[g] = in_valid & ~sent[g] & others_ready[g];
        end else begin : g_free
            assign out_valid[g] = in_valid & ~sent[g];
        end
    end

    assign in_ready = &(out_ready | sent);

endmodule

// File: rtl/stream_fanout.sv
module stream_fanout
    import fanout_pkg::*;
#(
    parameter int         DATA_W = 8,
    parameter int         N_OUT  = 3,
    parameter fork_mode_e MODE   = FORK_INDEPENDENT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DATA_W-1:0]       in_data,
    output logic [N_OUT-1:0]        out_valid,
    input  logic [N_OUT-1:0]        out_ready,
    output logic [N_OUT*DATA_W-1:0] out_data
);

    localparam bit LOCKSTEP = (MODE == FORK_LOCKSTEP);

    logic [N_OUT-1:0] sent;
    logic [N_OUT-1:0] out_fire;
    logic             in_fire;

    assign out_fire = out_valid & out_ready;
    assign in_fire  = in_valid & in_ready;

    if (LOCKSTEP) begin : g_no_flags
        assign sent = '0;
    end else begin : g_flags
        fanout_sent_flags #(
            .N_OUT (N_OUT)
        ) i_flags (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_fire  (in_fire),
            .out_fire (out_fire),
            .sent     (sent)
        );
    end

    fanout_offer #(
        .N_OUT    (N_OUT),
        .LOCKSTEP (LOCKSTEP)
    ) i_offer (
        .in_valid  (in_valid),
        .sent      (sent),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .in_ready  (in_ready)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_copy
        assign out_data[g*DATA_W +: DATA_W] = in_data;
    end

endmodule

// File: rtl/stream_fanout_checker.sv
module stream_fanout_checker #(
    parameter int DATA_W   = 8,
    parameter int N_OUT    = 3,
    parameter bit LOCKSTEP = 1'b0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [DATA_W-1:0]       in_data,
    input logic [N_OUT-1:0]        out_valid,
    input logic [N_OUT-1:0]        out_ready,
    input logic [N_OUT*DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] unused_data;
    assign unused_data = in_data ^ out_data[DATA_W-1:0];

    // R2, R3: in lockstep mode an input acceptance means every output fires
    a_r2_lock_all_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCKSTEP && in_valid && in_ready) |-> ((out_valid & out_ready) == {N_OUT{1'b1}}));

    // R3: in lockstep mode one output firing means all of them fire
    a_r3_lock_together: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCKSTEP && |(out_valid & out_ready)) |-> ((out_valid & out_ready) == {N_OUT{1'b1}}));

    // R6: in independent mode every output offers again after an acceptance
    a_r6_fresh_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (!LOCKSTEP && in_valid && in_ready) |=> (out_valid == {N_OUT{in_valid}}));

    // R8: idle input offers nothing
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (out_valid == '0));

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        // R4: a copy that left while the item is still held is not offered again
        a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
            (!LOCKSTEP && out_valid[g] && out_ready[g] && !in_ready) |=> !out_valid[g]);
    end

endmodule

bind stream_fanout stream_fanout_checker #(
    .DATA_W   (DATA_W),
    .N_OUT    (N_OUT),
    .LOCKSTEP (MODE == fanout_pkg::FORK_LOCKSTEP)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_stream_fanout.sv
`timescale 1ns/1ps
module test_stream_fanout;
    import fanout_pkg::*;

    localparam int DW = 8;
    localparam int NO = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [DW-1:0]   in_data = '0;
    logic [NO-1:0]   out_ready = '0;
    logic            ir_a, ir_s;
    logic [NO-1:0]   ov_a, ov_s;
    logic [NO*DW-1:0] od_a, od_s;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    stream_fanout #(.DATA_W(DW), .N_OUT(NO), .MODE(FORK_INDEPENDENT)) i_stream_fanout (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir_a), .in_data(in_data),
        .out_valid(ov_a), .out_ready(out_ready), .out_data(od_a));

    stream_fanout #(.DATA_W(DW), .N_OUT(NO), .MODE(FORK_LOCKSTEP)) i_stream_fanout_lock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir_s), .in_data(in_data),
        .out_valid(ov_s), .out_ready(out_ready), .out_data(od_s));

    // {valid, data[8], ready[3], indep out_valid[3], indep in_ready, lock out_valid[3], lock in_ready}
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 8'hA5, 3'b111, 3'b111, 1'b1, 3'b111, 1'b1},
        {1'b1, 8'h3C, 3'b001, 3'b111, 1'b0, 3'b000, 1'b0},
        {1'b1, 8'h3C, 3'b010, 3'b110, 1'b0, 3'b000, 1'b0},
        {1'b1, 8'h3C, 3'b100, 3'b100, 1'b1, 3'b000, 1'b0},
        {1'b0, 8'h00, 3'b111, 3'b000, 1'b1, 3'b000, 1'b1},
        {1'b1, 8'hF0, 3'b000, 3'b111, 1'b0, 3'b000, 1'b0},
        {1'b1, 8'hF0, 3'b101, 3'b111, 1'b0, 3'b010, 1'b0},
        {1'b1, 8'hF0, 3'b000, 3'b010, 1'b0, 3'b000, 1'b0},
        {1'b1, 8'hF0, 3'b111, 3'b010, 1'b1, 3'b111, 1'b1},
        {1'b1, 8'h81, 3'b110, 3'b111, 1'b0, 3'b001, 1'b0},
        {1'b1, 8'h81, 3'b001, 3'b001, 1'b1, 3'b000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_data(input string req);
        for (int k = 0; k < NO; k++) begin
            chk(req, 32'(od_a[k*DW +: DW]), 32'(in_data));
            chk(req, 32'(od_s[k*DW +: DW]), 32'(in_data));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // reset state
        #3;
        in_valid  = 1'b1;
        out_ready = 3'b000;
        #1;
        chk("R7 reset offer", 32'(ov_a), 32'b111);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1;
            in_valid  = VEC[i][19];
            in_data   = VEC[i][18:11];
            out_ready = VEC[i][10:8];
            #2;
            chk("R4/R6/R8 indep out_valid", 32'(ov_a), 32'(VEC[i][7:5]));
            chk("R5 indep in_ready",        32'(ir_a), 32'(VEC[i][4]));
            chk("R3 lock out_valid",        32'(ov_s), 32'(VEC[i][3:1]));
            chk("R2 lock in_ready",         32'(ir_s), 32'(VEC[i][0]));
            chk_data("R1 payload copy");
        end

        // R7: reset with one copy already sent
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'h5A; out_ready = 3'b001;
        @(posedge clk); #1;
        out_ready = 3'b000;
        #2;
        chk("R4 sent copy withheld", 32'(ov_a), 32'b110);
        rst_n = 1'b0;
        #1;
        chk("R7 flags cleared by reset", 32'(ov_a), 32'b111);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R7 offer after reset", 32'(ov_a), 32'b111);
        chk("R5 not ready after reset", 32'(ir_a), 32'b0);

        // R8: idle input with ready outputs sets no flag
        @(posedge clk); #1;
        in_valid = 1'b0; out_ready = 3'b111;
        #2;
        chk("R8 idle indep", 32'(ov_a), 32'b000);
        chk("R8 idle lock", 32'(ov_s), 32'b000);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'hC3; out_ready = 3'b000;
        #2;
        chk("R8 no flag set while idle", 32'(ov_a), 32'b111);
        chk_data("R1 payload after idle");

        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk);
        finish_run();
    end

endmodule